// File: doc/BRIEF.md
# Zero-Page Merged Register File

This block is one storage array of 260 bytes. Entries 0 to 255 hold the zero page and entries 256 to 259 hold the accumulator, the two index registers and the stack pointer. The pipeline reaches it through three register-side read ports and one register-side write port. A fourth read port serves the memory-side load path.

Every data load and store the core issues passes through the block's address decode. An access whose upper address byte is zero is taken from or written into the array and never reaches the external bus. Any other access is handed to the external read master or write master. When both masters want the bus in the same cycle, the write master wins. The array has only one write port. When a register write and a zero-page store arrive together, the register write lands first and the store is parked for one cycle, with a stall pulse for the pipeline. A read of an entry that is being written in the same cycle returns the new byte.

Top module: `zp_regfile`

## Requirements
- R1: After synchronous reset the accumulator (index 256), X (257) and Y (258) read 0x00, the stack pointer (259) reads 0xFF, and `stall` is low.
- R2: A register-side write to index i (0 to 259) is visible from the next cycle on every register read port at index i. For i below 256 it is also visible to a memory load at address 0x00ii.
- R3: A read on any port of the index committed in the same cycle returns the data being written in that cycle.
- R4: A load with upper address byte 0x00 returns array entry addr[7:0] on `mem_rd_data` in the same cycle, and `ext_rd_en` stays low.
- R5: A store with upper address byte 0x00 writes array entry addr[7:0] and keeps `ext_wr_en` low.
- R6: A store with a nonzero upper byte drives `ext_wr_en` high with the same address and data in the same cycle, and leaves the array unchanged.
- R7: A load with a nonzero upper byte drives `ext_rd_en` and `ext_rd_addr` in the same cycle and returns `ext_rd_data` on `mem_rd_data`.
- R8: When an external load and an external store fall in the same cycle, the store is issued, `ext_rd_en` stays low and `stall` is high.
- R9: A register write together with a zero-page store, while not busy, commits the register write in that cycle. `stall` is then high for exactly the next cycle, and the store commits at the end of that cycle (it is forwarded to reads during it).
- R10: During the busy cycle of R9, new register writes and new zero-page stores are ignored.
- R11: Indices 260 to 511 read 0x00, and a write to them changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx | input | 3x9 | Register-side read indices |
| rd_data | output | 3x8 | Register-side read data |
| rf_we | input | 1 | Register-side write enable |
| rf_widx | input | 9 | Register-side write index |
| rf_wdata | input | 8 | Register-side write data |
| mem_rd_en | input | 1 | Data load request |
| mem_rd_addr | input | 16 | Data load address |
| mem_rd_data | output | 8 | Data load result |
| mem_wr_en | input | 1 | Data store request |
| mem_wr_addr | input | 16 | Data store address |
| mem_wr_data | input | 8 | Data store byte |
| ext_rd_en | output | 1 | External read master request |
| ext_rd_addr | output | 16 | External read address |
| ext_rd_data | input | 8 | External read data |
| ext_wr_en | output | 1 | External write master request |
| ext_wr_addr | output | 16 | External write address |
| ext_wr_data | output | 8 | External write byte |
| stall | output | 1 | Pipeline hold request |

## Verification
The critical overlap is a register-side write and a zero-page store landing in the same cycle, because both need the single write port. The bench provokes this by raising `rf_we` together with a store to address 0x00xx. In the following cycle it offers fresh writes to both sources and reads the parked entry. It then judges three things: the register byte is present, the parked byte is forwarded while `stall` is high, and the offered writes leave the array unchanged once the busy cycle has passed. The bench also makes an external load and an external store coincide, to check the write-over-read priority.

// File: rtl/zpr_pkg.sv
package zpr_pkg;
    localparam int ZP_SIZE     = 256;
    localparam int NUM_SPECIAL = 4;
    localparam int NUM_ENTRIES = ZP_SIZE + NUM_SPECIAL;
    localparam int IDX_W       = $clog2(NUM_ENTRIES);
    localparam int ADDR_W      = 16;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [7:0]        byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam idx_t ZP_LIMIT  = idx_t'(ZP_SIZE);
    localparam idx_t ENT_LIMIT = idx_t'(NUM_ENTRIES);
    localparam idx_t IDX_A     = idx_t'(ZP_SIZE + 0);
    localparam idx_t IDX_X     = idx_t'(ZP_SIZE + 1);
    localparam idx_t IDX_Y     = idx_t'(ZP_SIZE + 2);
    localparam idx_t IDX_SP    = idx_t'(ZP_SIZE + 3);
    localparam byte_t SP_RESET = 8'hFF;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        byte_t data;
    } wr_req_t;

    function automatic logic addr_in_zp(input addr_t a);
        return a[ADDR_W-1:8] == '0;
    endfunction

    function automatic idx_t zp_entry(input addr_t a);
        return idx_t'(a[7:0]);
    endfunction
endpackage

// File: rtl/zpr_storage.sv
module zpr_storage
    import zpr_pkg::*;
#(
    parameter int N_PORTS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  wr_req_t               wr,
    input  idx_t  [N_PORTS-1:0]   ridx,
    output byte_t [N_PORTS-1:0]   rdata
);
    byte_t zp_q [ZP_SIZE];
    byte_t sr_q [NUM_SPECIAL];

    logic wr_ok;
    assign wr_ok = wr.en && (wr.idx < ENT_LIMIT);

    // zero page behaves like RAM: no reset fan-out on 256 bytes
    always_ff @(posedge clk) begin
        if (wr_ok && (wr.idx < ZP_LIMIT))
            zp_q[wr.idx[7:0]] <= wr.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q[0] <= '0;
            sr_q[1] <= '0;
            sr_q[2] <= '0;
            sr_q[3] <= SP_RESET;
        end else if (wr_ok && (wr.idx >= ZP_LIMIT)) begin
            sr_q[wr.idx[1:0]] <= wr.data;
        end
    end

    // each read port: write-first bypass, then array, then zero for out of range
    for (genvar p = 0; p < N_PORTS; p++) begin : g_rd
        assign rdata[p] = (wr_ok && (wr.idx == ridx[p])) ? wr.data :
                          (ridx[p] < ZP_LIMIT)           ? zp_q[ridx[p][7:0]] :
                          (ridx[p] < ENT_LIMIT)          ? sr_q[ridx[p][1:0]] :
                                                           '0;
    end
endmodule

// File: rtl/zpr_wr_arb.sv
module zpr_wr_arb
    import zpr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t rf_wr,
    input  wr_req_t zp_wr,
    output wr_req_t eff_wr,
    output logic    busy
);
    wr_req_t pend_q;
    logic    clash;

    assign clash = !rst && !pend_q.en && rf_wr.en && zp_wr.en;

    always_comb begin
        if (rst)
            eff_wr = '0;
        else if (pend_q.en)
            eff_wr = pend_q;          // parked store drains first
        else if (rf_wr.en)
            eff_wr = rf_wr;
        else
            eff_wr = zp_wr;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= '0;
        else if (clash)
            pend_q <= zp_wr;
        else
            pend_q <= '0;
    end

    assign busy = pend_q.en;
endmodule

// File: rtl/zpr_redirect.sv
module zpr_redirect
    import zpr_pkg::*;
(
    input  logic  mem_rd_en,
    input  addr_t mem_rd_addr,
    input  logic  mem_wr_en,
    input  addr_t mem_wr_addr,
    input  byte_t mem_wr_data,
    input  byte_t zp_rd_data,
    input  byte_t ext_rd_data,
    output idx_t  zp_rd_idx,
    output wr_req_t zp_wr,
    output byte_t mem_rd_data,
    output logic  ext_rd_en,
    output addr_t ext_rd_addr,
    output logic  ext_wr_en,
    output addr_t ext_wr_addr,
    output byte_t ext_wr_data,
    output logic  rd_blocked
);
    logic rd_local, wr_local, ext_rd_want;

    assign rd_local = addr_in_zp(mem_rd_addr);
    assign wr_local = addr_in_zp(mem_wr_addr);

    assign zp_rd_idx    = zp_entry(mem_rd_addr);
    assign zp_wr.en     = mem_wr_en && wr_local;
    assign zp_wr.idx    = zp_entry(mem_wr_addr);
    assign zp_wr.data   = mem_wr_data;

    assign ext_wr_en    = mem_wr_en && !wr_local;
    assign ext_wr_addr  = mem_wr_addr;
    assign ext_wr_data  = mem_wr_data;

    assign ext_rd_want  = mem_rd_en && !rd_local;
    assign ext_rd_en    = ext_rd_want && !ext_wr_en;
    assign ext_rd_addr  = mem_rd_addr;
    assign rd_blocked   = ext_rd_want && ext_wr_en;

    assign mem_rd_data  = rd_local ? zp_rd_data : ext_rd_data;
endmodule

// File: rtl/zp_regfile.sv
module zp_regfile
    import zpr_pkg::*;
#(
    parameter int N_REG_RD = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_REG_RD-1:0][8:0] rd_idx,
    output logic [N_REG_RD-1:0][7:0] rd_data,
    input  logic                    rf_we,
    input  logic [8:0]              rf_widx,
    input  logic [7:0]              rf_wdata,
    input  logic                    mem_rd_en,
    input  logic [15:0]             mem_rd_addr,
    output logic [7:0]              mem_rd_data,
    input  logic                    mem_wr_en,
    input  logic [15:0]             mem_wr_addr,
    input  logic [7:0]              mem_wr_data,
    output logic                    ext_rd_en,
    output logic [15:0]             ext_rd_addr,
    input  logic [7:0]              ext_rd_data,
    output logic                    ext_wr_en,
    output logic [15:0]             ext_wr_addr,
    output logic [7:0]              ext_wr_data,
    output logic                    stall
);
    localparam int N_PORTS = N_REG_RD + 1;
    localparam int MEM_PORT = N_REG_RD;

    wr_req_t rf_wr, zp_wr, eff_wr;
    idx_t  [N_PORTS-1:0] ridx;
    byte_t [N_PORTS-1:0] rdata;
    idx_t  zp_rd_idx;
    logic  busy, rd_blocked;

    assign rf_wr.en   = rf_we;
    assign rf_wr.idx  = rf_widx;
    assign rf_wr.data = rf_wdata;

    for (genvar p = 0; p < N_REG_RD; p++) begin : g_port
        assign ridx[p]    = rd_idx[p];
        assign rd_data[p] = rdata[p];
    end
    assign ridx[MEM_PORT] = zp_rd_idx;

    zpr_redirect u_redir (
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data),
        .zp_rd_data  (rdata[MEM_PORT]),
        .ext_rd_data (ext_rd_data),
        .zp_rd_idx   (zp_rd_idx),
        .zp_wr       (zp_wr),
        .mem_rd_data (mem_rd_data),
        .ext_rd_en   (ext_rd_en),
        .ext_rd_addr (ext_rd_addr),
        .ext_wr_en   (ext_wr_en),
        .ext_wr_addr (ext_wr_addr),
        .ext_wr_data (ext_wr_data),
        .rd_blocked  (rd_blocked)
    );

    zpr_wr_arb u_arb (
        .clk    (clk),
        .rst    (rst),
        .rf_wr  (rf_wr),
        .zp_wr  (zp_wr),
        .eff_wr (eff_wr),
        .busy   (busy)
    );

    zpr_storage #(.N_PORTS(N_PORTS)) u_store (
        .clk   (clk),
        .rst   (rst),
        .wr    (eff_wr),
        .ridx  (ridx),
        .rdata (rdata)
    );

    assign stall = busy | rd_blocked;
endmodule

// File: rtl/zp_regfile_chk.sv
module zp_regfile_chk (
    input logic        clk,
    input logic        rst,
    input logic        rf_we,
    input logic [8:0]  rf_widx,
    input logic [7:0]  rf_wdata,
    input logic [8:0]  rd_idx0,
    input logic [7:0]  rd_data0,
    input logic        mem_rd_en,
    input logic [7:0]  mem_rd_hi,
    input logic        mem_wr_en,
    input logic [15:0] mem_wr_addr,
    input logic        ext_rd_en,
    input logic        ext_wr_en,
    input logic [15:0] ext_wr_addr,
    input logic        stall
);
    assert_zp_load_local_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && mem_rd_hi == 8'h00) |-> !ext_rd_en);

    assert_zp_store_local_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && mem_wr_addr[15:8] == 8'h00) |-> !ext_wr_en);

    assert_far_store_out_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && mem_wr_addr[15:8] != 8'h00) |-> (ext_wr_en && ext_wr_addr == mem_wr_addr));

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
        ext_rd_en |-> !ext_wr_en);

    assert_blocked_load_stalls_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && mem_rd_hi != 8'h00 && ext_wr_en) |-> stall);

    assert_clash_then_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (rf_we && mem_wr_en && mem_wr_addr[15:8] == 8'h00 && !stall) |=> stall);

    assert_bypass_new_data_R3: assert property (@(posedge clk) disable iff (rst)
        (rf_we && !stall && rf_widx == rd_idx0 && rf_widx < 9'd260) |-> (rd_data0 == rf_wdata));

    assert_out_of_range_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_idx0 >= 9'd260) |-> (rd_data0 == 8'h00));
endmodule

bind zp_regfile zp_regfile_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rf_we       (rf_we),
    .rf_widx     (rf_widx),
    .rf_wdata    (rf_wdata),
    .rd_idx0     (rd_idx[0]),
    .rd_data0    (rd_data[0]),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_hi   (mem_rd_addr[15:8]),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr),
    .ext_rd_en   (ext_rd_en),
    .ext_wr_en   (ext_wr_en),
    .ext_wr_addr (ext_wr_addr),
    .stall       (stall)
);

// File: tb/sim_zp_regfile.sv
module sim_zp_regfile;
    localparam int NR = 3;
    localparam logic [8:0] I_A = 9'd256, I_X = 9'd257, I_Y = 9'd258, I_SP = 9'd259;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic              rst;
    logic [NR-1:0][8:0] rd_idx;
    logic [NR-1:0][7:0] rd_data;
    logic        rf_we;
    logic [8:0]  rf_widx;
    logic [7:0]  rf_wdata;
    logic        mem_rd_en, mem_wr_en;
    logic [15:0] mem_rd_addr, mem_wr_addr;
    logic [7:0]  mem_rd_data, mem_wr_data;
    logic        ext_rd_en, ext_wr_en;
    logic [15:0] ext_rd_addr, ext_wr_addr;
    logic [7:0]  ext_rd_data, ext_wr_data;
    logic        stall;

    zp_regfile #(.N_REG_RD(NR)) u0 (
        .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_data(rd_data),
        .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .ext_rd_en(ext_rd_en), .ext_rd_addr(ext_rd_addr), .ext_rd_data(ext_rd_data),
        .ext_wr_en(ext_wr_en), .ext_wr_addr(ext_wr_addr), .ext_wr_data(ext_wr_data),
        .stall(stall)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        int          cyc;
        int          sel;
        logic [15:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    // sel: 0..2 rd_data, 3 mem_rd_data, 4 stall, 5 ext_rd_en, 6 ext_wr_en,
    //      7 ext_wr_addr, 8 ext_rd_addr, 9 ext_wr_data
    function automatic logic [15:0] probe(int sel);
        case (sel)
            0: return {8'h00, rd_data[0]};
            1: return {8'h00, rd_data[1]};
            2: return {8'h00, rd_data[2]};
            3: return {8'h00, mem_rd_data};
            4: return {15'h0, stall};
            5: return {15'h0, ext_rd_en};
            6: return {15'h0, ext_wr_en};
            7: return ext_wr_addr;
            8: return ext_rd_addr;
            default: return {8'h00, ext_wr_data};
        endcase
    endfunction

    task automatic want(int sel, logic [15:0] exp, string req);
        item_t it;
        it.cyc = cyc; it.sel = sel; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    // monitor: compares queued expectations in the middle of their cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            item_t it;
            logic [15:0] got;
            it  = sb.pop_front();
            got = probe(it.sel);
            checks++;
            if (it.cyc != cyc || got !== it.exp) begin
                fails++;
                $display("FAIL %s: probe %0d got %h expected %h (cycle %0d)",
                         it.req, it.sel, got, it.exp, it.cyc);
            end
        end
    end

    task automatic quiet();
        rf_we = 0; rf_widx = '0; rf_wdata = '0;
        mem_rd_en = 0; mem_rd_addr = '0;
        mem_wr_en = 0; mem_wr_addr = '0; mem_wr_data = '0;
        ext_rd_data = '0;
        for (int p = 0; p < NR; p++) rd_idx[p] = '0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic rf_write(logic [8:0] i, logic [7:0] d);
        rf_we = 1; rf_widx = i; rf_wdata = d;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst = 1; quiet();
        repeat (2) @(posedge clk);
        #1; rst = 0;

        // R1: reset values
        rd_idx[0] = I_A; rd_idx[1] = I_X; rd_idx[2] = I_Y;
        want(0, 16'h00, "R1"); want(1, 16'h00, "R1"); want(2, 16'h00, "R1");
        want(4, 16'h0, "R1");
        step();
        rd_idx[0] = I_SP;
        want(0, 16'hFF, "R1");
        step();

        // R2: register write then read, zero-page write seen by load
        quiet(); rf_write(I_A, 8'h3C); step();
        quiet(); rd_idx[1] = I_A; want(1, 16'h3C, "R2"); step();
        quiet(); rf_write(9'h010, 8'hA5); step();
        quiet(); mem_rd_en = 1; mem_rd_addr = 16'h0010;
        want(3, 16'hA5, "R2"); want(5, 16'h0, "R4");
        step();

        // R3: same-cycle forwarding on register port and load path
        quiet(); rf_write(I_X, 8'h77); rd_idx[2] = I_X;
        want(2, 16'h77, "R3"); step();
        quiet(); rf_write(9'h020, 8'h5A); mem_rd_en = 1; mem_rd_addr = 16'h0020;
        want(3, 16'h5A, "R3"); step();

        // R5: zero-page store stays local
        quiet(); mem_wr_en = 1; mem_wr_addr = 16'h0030; mem_wr_data = 8'hC3;
        want(6, 16'h0, "R5"); step();
        quiet(); rd_idx[0] = 9'h030; want(0, 16'hC3, "R5"); step();

        // R6: far store goes out, array untouched
        quiet(); mem_wr_en = 1; mem_wr_addr = 16'h1230; mem_wr_data = 8'h99;
        want(6, 16'h1, "R6"); want(7, 16'h1230, "R6"); want(9, 16'h99, "R6");
        step();
        quiet(); rd_idx[0] = 9'h030; want(0, 16'hC3, "R6"); step();

        // R7: far load goes out
        quiet(); mem_rd_en = 1; mem_rd_addr = 16'h4455; ext_rd_data = 8'hE1;
        want(5, 16'h1, "R7"); want(8, 16'h4455, "R7"); want(3, 16'hE1, "R7");
        want(4, 16'h0, "R7");
        step();

        // R8: external store beats external load
        quiet(); mem_rd_en = 1; mem_rd_addr = 16'h4455;
        mem_wr_en = 1; mem_wr_addr = 16'h8000; mem_wr_data = 8'h01;
        want(5, 16'h0, "R8"); want(4, 16'h1, "R8"); want(6, 16'h1, "R8");
        step();

        // R9 / R10: write-port clash, then ignored writes while busy
        quiet(); rf_write(9'h050, 8'h66); step();
        quiet(); rf_write(I_Y, 8'h11);
        mem_wr_en = 1; mem_wr_addr = 16'h0040; mem_wr_data = 8'h22;
        want(4, 16'h0, "R9");
        step();
        quiet(); rf_write(9'h040, 8'h33);
        mem_wr_en = 1; mem_wr_addr = 16'h0050; mem_wr_data = 8'h44;
        rd_idx[0] = I_Y; rd_idx[1] = 9'h040;
        want(0, 16'h11, "R9"); want(1, 16'h22, "R9"); want(4, 16'h1, "R9");
        step();
        quiet(); rd_idx[0] = 9'h040; rd_idx[1] = 9'h050;
        want(0, 16'h22, "R10"); want(1, 16'h66, "R10"); want(4, 16'h0, "R9");
        step();

        // R11: out-of-range index
        quiet(); rf_write(9'h02C, 8'h01); step();
        quiet(); rf_write(9'd300, 8'hFF); rd_idx[0] = 9'd300;
        want(0, 16'h00, "R11"); step();
        quiet(); rd_idx[0] = 9'd300; rd_idx[1] = 9'h02C; rd_idx[2] = I_A;
        want(0, 16'h00, "R11"); want(1, 16'h01, "R11"); want(2, 16'h3C, "R11");
        step();

        quiet();
        @(negedge clk);
        #1;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        done = 1;
        finish_run();
    end
endmodule